// File: doc/BRIEF.md
# Occupancy-Counted Synchronous FIFO

A single-clock first-in first-out buffer holding eight bytes. The producer and consumer raise their request lines without looking at the status flags. The buffer decides, in the same cycle, whether each request is taken. It reports that decision on an accept line for each side. A refused request has no effect. The requester sees the refusal before the clock edge and presents the same request again in the next cycle.

Occupancy comes from a dedicated up/down counter. The accept lines drive it, not the difference between the pointers. The counter holds a value from 0 to 8. The full and empty flags are decoded from it. Read data is registered and is valid in the cycle after an accepted read.

The asynchronous active-low reset is expected to be released in step with the clock by the surrounding reset logic.

Top module: `occ_fifo`

## Requirements
- R1: While reset is low, and at the first clock after its release, level is 0, empty is 1, full is 0 and rd_data is 0.
- R2: wr_acc is 1 exactly when wr_req is 1 and full is 0. An accepted write stores wr_data at the clock edge.
- R3: rd_acc is 1 exactly when rd_req is 1 and empty is 0. A read request while empty is refused.
- R4: The level counter behaves as follows at each clock edge:
  - it rises by one when only wr_acc is 1;
  - it falls by one when only rd_acc is 1;
  - it holds when both accept lines are 1 or both are 0.
- R5: level never exceeds 8. full is 1 exactly when level is 8, and empty is 1 exactly when level is 0.
- R6: An accepted read places the oldest stored byte on rd_data after that clock edge. Bytes leave in the order they were accepted.
- R7: A refused read leaves rd_data and level unchanged. A retry in the next cycle that is accepted returns the byte that was pending.
- R8: A write refused while full stores nothing. The eight bytes already held later drain unchanged.
- R9: Requests on both sides in the same cycle are resolved as follows:
  - while full, only the read is accepted and level drops to 7;
  - while empty, only the write is accepted and level rises to 1;
  - otherwise both are accepted and level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Raw write request from producer |
| wr_data | input | 8 | Byte to store |
| rd_req | input | 1 | Raw read request from consumer |
| rd_data | output | 8 | Registered output byte |
| full | output | 1 | Buffer holds 8 bytes |
| empty | output | 1 | Buffer holds no bytes |
| wr_acc | output | 1 | Write request accepted this cycle |
| rd_acc | output | 1 | Read request accepted this cycle |
| level | output | 4 | Current occupancy, 0 to 8 |

## Verification
The checker watches the following on every cycle:
- how the counter steps for each combination of accept lines;
- the upper bound on level;
- that no accept is granted against the matching flag;
- that rd_data holds across a refused read.

Data ordering, the integrity of contents after writes refused while full, and retry returning the pending byte are visible only through the bench's scenarios. In those scenarios a reference queue is filled to the limit, drained to empty, and exercised with mixed random traffic.

// File: rtl/occ_fifo_pkg.sv
package occ_fifo_pkg;

  // Counter step selected from the qualified enables
  typedef enum logic [1:0] {
    CNT_HOLD = 2'b00,
    CNT_UP   = 2'b01,
    CNT_DOWN = 2'b10
  } cnt_op_e;

  function automatic cnt_op_e step_of(input logic w_ok, input logic r_ok);
    cnt_op_e op;
    unique case ({w_ok, r_ok})
      2'b10:   op = CNT_UP;
      2'b01:   op = CNT_DOWN;
      default: op = CNT_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/occ_qualify.sv
module occ_qualify
  import occ_fifo_pkg::*;
(
  input  logic    wr_req,
  input  logic    rd_req,
  input  logic    full,
  input  logic    empty,
  output logic    wr_acc,
  output logic    rd_acc,
  output cnt_op_e cnt_op
);

  // Refusal is decided from the registered flags within the request cycle
  always_comb begin
    wr_acc = wr_req & ~full;
    rd_acc = rd_req & ~empty;
    cnt_op = step_of(wr_acc, rd_acc);
  end

endmodule

// File: rtl/occ_counter.sv
module occ_counter
  import occ_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          cnt_op,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);

  localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);

  logic             cnt_en;
  logic [CNT_W-1:0] level_d;

  // Enable is off when both or neither side is accepted
  always_comb begin
    cnt_en  = (cnt_op != CNT_HOLD);
    level_d = level;
    if (cnt_op == CNT_UP)   level_d = level + 1'b1;
    if (cnt_op == CNT_DOWN) level_d = level - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (cnt_en) level <= level_d;
  end

  always_comb begin
    full  = (level == LVL_MAX);
    empty = (level == '0);
  end

endmodule

// File: rtl/occ_store.sv
module occ_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wptr, rptr, wptr_d, rptr_d;
  logic [DATA_W-1:0] slot [DEPTH];

  // Pointer advance, wrapping at the last slot for any depth
  always_comb begin
    wptr_d = (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
    rptr_d = (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= wptr_d;
      if (rd_en) rptr <= rptr_d;
    end
  end

  // One enabled register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wptr == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we) slot[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= slot[rptr];
  end

endmodule

// File: rtl/occ_fifo.sv
module occ_fifo
  import occ_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_req,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_req,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       full,
  output logic                       empty,
  output logic                       wr_acc,
  output logic                       rd_acc,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  cnt_op_e cnt_op;

  occ_qualify u_qual (
    .wr_req (wr_req),
    .rd_req (rd_req),
    .full   (full),
    .empty  (empty),
    .wr_acc (wr_acc),
    .rd_acc (rd_acc),
    .cnt_op (cnt_op)
  );

  occ_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_op (cnt_op),
    .level  (level),
    .full   (full),
    .empty  (empty)
  );

  occ_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_acc),
    .wr_data (wr_data),
    .rd_en   (rd_acc),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/occ_fifo_checker.sv
module occ_fifo_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              full,
  input logic              empty,
  input logic              wr_acc,
  input logic              rd_acc,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  level
);

  assert_no_write_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_acc);

  assert_no_read_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_acc);

  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !rd_acc) |=> (level == CNT_W'($past(level) + 1'b1)));

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !wr_acc) |=> (level == CNT_W'($past(level) - 1'b1)));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc == rd_acc) |=> $stable(level));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  assert_refused_read_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(rd_data));

endmodule

bind occ_fifo occ_fifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .full    (full),
  .empty   (empty),
  .wr_acc  (wr_acc),
  .rd_acc  (rd_acc),
  .rd_data (rd_data),
  .level   (level)
);

// File: tb/tb_occ_fifo.sv
module tb_occ_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int WATCHDOG   = 50000;

  logic       clk, rst_n, wr_req, rd_req;
  logic [7:0] wr_data, rd_data;
  logic       full, empty, wr_acc, rd_acc;
  logic [3:0] level;

  occ_fifo dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .wr_data (wr_data),
    .rd_req  (rd_req),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty),
    .wr_acc  (wr_acc),
    .rd_acc  (rd_acc),
    .level   (level)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference queue
  logic [7:0] q [DEPTH];
  int q_head = 0;
  int q_cnt  = 0;
  logic [7:0] exp_rd = 8'h00;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_wacc(input bit wreq);
    return wreq && (q_cnt < DEPTH);
  endfunction

  function automatic bit exp_racc(input bit rreq);
    return rreq && (q_cnt > 0);
  endfunction

  // One cycle: drive at negedge, check qualifiers, clock, check results
  task automatic step(input bit wreq, input logic [7:0] wd, input bit rreq);
    bit ew, er;
    wr_req  = wreq;
    wr_data = wd;
    rd_req  = rreq;
    #1;
    ew = exp_wacc(wreq);
    er = exp_racc(rreq);
    chk(wr_acc == ew, "R2 wr_acc", int'(wr_acc), int'(ew));
    chk(rd_acc == er, "R3 rd_acc", int'(rd_acc), int'(er));
    @(posedge clk);
    if (er) begin
      exp_rd = q[q_head];
      q_head = (q_head + 1) % DEPTH;
      q_cnt--;
    end
    if (ew) begin
      q[(q_head + q_cnt) % DEPTH] = wd;
      q_cnt++;
    end
    @(negedge clk);
    chk(int'(level) == q_cnt, "R4 level", int'(level), q_cnt);
    chk(full == (q_cnt == DEPTH), "R5 full", int'(full), int'(q_cnt == DEPTH));
    chk(empty == (q_cnt == 0), "R5 empty", int'(empty), int'(q_cnt == 0));
    chk(rd_data == exp_rd, "R6 rd_data", int'(rd_data), int'(exp_rd));
    wr_req = 1'b0;
    rd_req = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    logic [7:0] held;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; wr_data = 8'h00;
    #(CLK_PERIOD*2 + 2);
    // R1: state under reset
    chk(level == 4'd0, "R1 level", int'(level), 0);
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(rd_data == 8'h00, "R1 rd_data", int'(rd_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(level == 4'd0 && empty, "R1 after release", int'(level), 0);

    // R3/R7: read while empty refused, rd_data held
    step(1'b0, 8'h00, 1'b1);
    chk(rd_data == 8'h00, "R7 rd_data held on refusal", int'(rd_data), 0);
    // R9: both while empty -> only write accepted
    step(1'b1, 8'hA5, 1'b1);
    chk(level == 4'd1, "R9 empty both level", int'(level), 1);
    // R6/R7: retry read returns pending byte
    step(1'b0, 8'h00, 1'b1);
    chk(rd_data == 8'hA5, "R7 retry data", int'(rd_data), 8'hA5);

    // R5/R8: fill to full then push while full
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h10 + i), 1'b0);
    chk(full && level == 4'd8, "R5 full at 8", int'(level), 8);
    step(1'b1, 8'hEE, 1'b0);
    step(1'b1, 8'hEF, 1'b0);
    chk(level == 4'd8, "R8 level after refused write", int'(level), 8);
    // R9: both while full -> only read
    step(1'b1, 8'hDD, 1'b1);
    chk(level == 4'd7 && rd_data == 8'h10, "R9 full both", int'(level), 7);
    // R9: both while partial -> level holds
    step(1'b1, 8'h77, 1'b1);
    chk(level == 4'd7, "R9 partial both", int'(level), 7);
    // R8: drain all; reference queue checks order and no corruption
    while (q_cnt > 0) step(1'b0, 8'h00, 1'b1);
    held = rd_data;
    step(1'b0, 8'h00, 1'b1);
    chk(rd_data == held, "R7 drained refusal hold", int'(rd_data), int'(held));

    // Random traffic, biased in phases to reach both ends
    for (int ph = 0; ph < 6; ph++) begin
      for (int n = 0; n < 400; n++) begin
        int wp;
        int rp;
        wp = (ph % 2 == 0) ? 80 : 30;
        rp = (ph % 2 == 0) ? 30 : 80;
        step(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < rp);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule